// File: doc/BRIEF.md
# Non-Volatile Media Access Interface

This block sits between a memory controller and a non-volatile media device whose access latency is not fixed and can have a long tail. It accepts read and write requests on one request port. A read is handled in two stages. In the first stage the block allocates a tag, records the address in an outstanding-read table, and places a read command on the media command bus. In the second stage the media later signals that data for a tag is ready. That event triggers a response burst back to the controller, which carries the tag, the original address and the data. Responses can return in any order.

Writes do not wait for the media. Each write's address and one data beat go into a small near-media write buffer, which sends them to the media in arrival order. An entry stays in the buffer until the media reports that its write is complete. When every entry is in use, the buffer refuses further writes. Reads and writes share a single media command bus. A command that the media has not accepted stays on the bus unchanged. A waiting read command is chosen ahead of a waiting write.

Top module: `nvm_media_if`

## Requirements
- R1: After reset, no read is outstanding and the write buffer is empty. `req_ready` is 1, and both `md_cmd_valid` and `rsp_valid` are 0.
- R2: An accepted read takes the lowest-numbered free tag, which `req_tag` shows in the accepting cycle. From the next cycle, a read command (`md_cmd_write`=0) is shown with that tag and the request address.
- R3: While all 2**TAG_W tags are outstanding, `req_ready` is 0 for read requests.
- R4: When `md_rd_ready` names an outstanding tag, `rsp_valid` is 1 in the next cycle, with that tag, the address recorded for it and `md_rd_data`. The tag then becomes free. Tags may complete in any order.
- R5: When `md_rd_ready` names a tag that is not outstanding, no response is produced and no table state changes.
- R6: An accepted write is shown on the media bus (`md_cmd_write`=1) with its address and data. Writes go out in the order they were accepted.
- R7: While WB_DEPTH write entries have not been released, `req_ready` is 0 for write requests. Read requests are still judged on their own conditions.
- R8: A write entry is released only by `md_wr_done` while at least one issued write is waiting for completion, and releases go in issue order. A `md_wr_done` with no issued write waiting is ignored.
- R9: When no command is stalled on the bus, a waiting read command is shown ahead of any unissued write.
- R10: While `md_cmd_valid` is 1 and `md_cmd_ready` is 0, the command on the bus and its fields stay unchanged in the next cycle.
- R11: Only one read command waits for the media bus at a time. While one waits, `req_ready` is 0 for read requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid (depends on `req_write`) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data beat |
| req_tag | output | TAG_W | Tag given to a read accepted this cycle |
| rsp_valid | output | 1 | Read response pulse |
| rsp_tag | output | TAG_W | Tag of the response |
| rsp_addr | output | ADDR_W | Address recorded for that tag |
| rsp_data | output | DATA_W | Read data |
| md_cmd_valid | output | 1 | Media command present |
| md_cmd_ready | input | 1 | Media takes the command |
| md_cmd_write | output | 1 | 1 = write command, 0 = read command |
| md_cmd_addr | output | ADDR_W | Command address |
| md_cmd_tag | output | TAG_W | Read tag (0 for writes) |
| md_cmd_wdata | output | DATA_W | Write data (0 for reads) |
| md_rd_ready | input | 1 | Media has read data for `md_rd_tag` |
| md_rd_tag | input | TAG_W | Tag of the ready read |
| md_rd_data | input | DATA_W | Read data from media |
| md_wr_done | input | 1 | Oldest issued write has completed |

## Verification
Suppose a tag bit in the outstanding table goes wrong. A stray ready would then give a response, or a real one would be lost, and `rsp_valid` shows this one cycle after `md_rd_ready`. A wrong buffer count or pointer shows up in the accepting cycle, as `req_ready` disagreeing for writes. It can also show as the wrong address or data on the next write command placed on the media bus. Arbitration or hold errors show up on the media bus in the cycle after a stalled or competing command.

// File: rtl/nvm_if_pkg.sv
package nvm_if_pkg;

  // Which source owns the media command bus
  typedef enum logic {
    SRC_RD = 1'b0,
    SRC_WR = 1'b1
  } cmd_src_e;

endpackage

// File: rtl/nvm_rd_table.sv
module nvm_rd_table #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  output logic [TAG_W-1:0]  alloc_tag_o,
  output logic              full_o,
  output logic              pend_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic [TAG_W-1:0]  pend_tag_o,
  input  logic              pend_iss_i,
  input  logic              md_rd_ready_i,
  input  logic [TAG_W-1:0]  md_rd_tag_i,
  input  logic [DATA_W-1:0] md_rd_data_i,
  output logic              rsp_valid_o,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [DATA_W-1:0] rsp_data_o
);

  localparam int NTAG = 1 << TAG_W;

  logic [NTAG-1:0]   busy_q, busy_d;
  logic [ADDR_W-1:0] addr_q [NTAG];
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [TAG_W-1:0]  pend_tag_q;
  logic              rsp_v_q;
  logic [TAG_W-1:0]  rsp_tag_q;
  logic [ADDR_W-1:0] rsp_addr_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [TAG_W-1:0]  alloc;
  logic              hit;

  // Lowest free tag
  always_comb begin
    alloc = '0;
    for (int i = NTAG - 1; i >= 0; i--) begin
      if (!busy_q[i]) alloc = TAG_W'(i);
    end
  end

  assign hit = md_rd_ready_i && busy_q[md_rd_tag_i];

  always_comb begin
    busy_d = busy_q;
    if (acc_i) busy_d[alloc] = 1'b1;
    if (hit)   busy_d[md_rd_tag_i] = 1'b0;
    pend_d = pend_q;
    if (pend_iss_i) pend_d = 1'b0;
    if (acc_i)      pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      pend_q  <= 1'b0;
      rsp_v_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      pend_q  <= pend_d;
      rsp_v_q <= hit;
    end
  end

  for (genvar g = 0; g < NTAG; g++) begin : g_addr
    always_ff @(posedge clk) begin
      if (acc_i && (alloc == TAG_W'(g))) addr_q[g] <= acc_addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr_q <= '0;
      pend_tag_q  <= '0;
    end else if (acc_i) begin
      pend_addr_q <= acc_addr_i;
      pend_tag_q  <= alloc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_tag_q  <= '0;
      rsp_addr_q <= '0;
      rsp_data_q <= '0;
    end else if (hit) begin
      rsp_tag_q  <= md_rd_tag_i;
      rsp_addr_q <= addr_q[md_rd_tag_i];
      rsp_data_q <= md_rd_data_i;
    end
  end

  assign alloc_tag_o = alloc;
  assign full_o      = &busy_q;
  assign pend_o      = pend_q;
  assign pend_addr_o = pend_addr_q;
  assign pend_tag_o  = pend_tag_q;
  assign rsp_valid_o = rsp_v_q;
  assign rsp_tag_o   = rsp_tag_q;
  assign rsp_addr_o  = rsp_addr_q;
  assign rsp_data_o  = rsp_data_q;

  // R4
  rd_hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> rsp_valid_o && (rsp_tag_o == $past(md_rd_tag_i)) && !busy_q[$past(md_rd_tag_i)]);

  // R5
  stray_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (md_rd_ready_i && !busy_q[md_rd_tag_i]) |=> !rsp_valid_o);

  // R3
  alloc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |-> ($countones(busy_q) < NTAG));

  // R11
  single_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |-> !pend_q);

endmodule

// File: rtl/nvm_wr_buf.sv
module nvm_wr_buf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic              full_o,
  output logic              iss_valid_o,
  output logic [ADDR_W-1:0] iss_addr_o,
  output logic [DATA_W-1:0] iss_data_o,
  input  logic              iss_i,
  input  logic              done_i
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] mem_addr [DEPTH];
  logic [DATA_W-1:0] mem_data [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  iss_ptr_q, iss_ptr_d;
  logic [PTR_W-1:0]  rel_ptr_q, rel_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  infl_q, infl_d;
  logic              rel;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign rel = done_i && (infl_q != '0);

  always_comb begin
    wr_ptr_d  = push_i ? bump(wr_ptr_q)  : wr_ptr_q;
    iss_ptr_d = iss_i  ? bump(iss_ptr_q) : iss_ptr_q;
    rel_ptr_d = rel    ? bump(rel_ptr_q) : rel_ptr_q;
    cnt_d     = cnt_q  + CNT_W'(push_i) - CNT_W'(rel);
    infl_d    = infl_q + CNT_W'(iss_i)  - CNT_W'(rel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q  <= '0;
      iss_ptr_q <= '0;
      rel_ptr_q <= '0;
      cnt_q     <= '0;
      infl_q    <= '0;
    end else begin
      wr_ptr_q  <= wr_ptr_d;
      iss_ptr_q <= iss_ptr_d;
      rel_ptr_q <= rel_ptr_d;
      cnt_q     <= cnt_d;
      infl_q    <= infl_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (push_i && (wr_ptr_q == PTR_W'(g))) begin
        mem_addr[g] <= push_addr_i;
        mem_data[g] <= push_data_i;
      end
    end
  end

  assign full_o      = (cnt_q == CNT_W'(DEPTH));
  assign iss_valid_o = (cnt_q != infl_q);
  assign iss_addr_o  = mem_addr[iss_ptr_q];
  assign iss_data_o  = mem_data[iss_ptr_q];

  // R7
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q < CNT_W'(DEPTH)));

  // R8
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && (infl_q == '0) && !push_i) |=> $stable(cnt_q));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && (infl_q != '0) && !push_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R6
  iss_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_i |-> (cnt_q > infl_q));

endmodule

// File: rtl/nvm_cmd_arb.sv
module nvm_cmd_arb
  import nvm_if_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_v_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic              wr_v_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              md_ready_i,
  output logic              md_valid_o,
  output logic              md_write_o,
  output logic [ADDR_W-1:0] md_addr_o,
  output logic [TAG_W-1:0]  md_tag_o,
  output logic [DATA_W-1:0] md_wdata_o,
  output logic              rd_iss_o,
  output logic              wr_iss_o
);

  logic     held_q, held_d;
  cmd_src_e src_q, src;

  // A stalled command keeps the bus; otherwise reads go first
  always_comb begin
    if (held_q)      src = src_q;
    else if (rd_v_i) src = SRC_RD;
    else             src = SRC_WR;
  end

  always_comb begin
    if (src == SRC_WR) begin
      md_valid_o = wr_v_i;
      md_write_o = 1'b1;
      md_addr_o  = wr_addr_i;
      md_tag_o   = '0;
      md_wdata_o = wr_data_i;
    end else begin
      md_valid_o = rd_v_i;
      md_write_o = 1'b0;
      md_addr_o  = rd_addr_i;
      md_tag_o   = rd_tag_i;
      md_wdata_o = '0;
    end
    held_d = md_valid_o && !md_ready_i;
  end

  assign rd_iss_o = md_valid_o && md_ready_i && (src == SRC_RD);
  assign wr_iss_o = md_valid_o && md_ready_i && (src == SRC_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      src_q  <= SRC_RD;
    end else begin
      held_q <= held_d;
      src_q  <= src;
    end
  end

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (md_valid_o && !md_ready_i) |=> md_valid_o && $stable(md_write_o) &&
      $stable(md_addr_o) && $stable(md_tag_o) && $stable(md_wdata_o));

  // R9
  rd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_q && rd_v_i) |-> (md_valid_o && !md_write_o));

endmodule

// File: rtl/nvm_media_if.sv
module nvm_media_if #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 3,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [DATA_W-1:0] rsp_data,
  output logic              md_cmd_valid,
  input  logic              md_cmd_ready,
  output logic              md_cmd_write,
  output logic [ADDR_W-1:0] md_cmd_addr,
  output logic [TAG_W-1:0]  md_cmd_tag,
  output logic [DATA_W-1:0] md_cmd_wdata,
  input  logic              md_rd_ready,
  input  logic [TAG_W-1:0]  md_rd_tag,
  input  logic [DATA_W-1:0] md_rd_data,
  input  logic              md_wr_done
);

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic              rd_full, rd_pend, wb_full;
  logic [ADDR_W-1:0] pend_addr;
  logic [TAG_W-1:0]  pend_tag;
  logic              acc_rd, push_wr;
  logic              rd_iss, wr_iss;
  logic              wb_v;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign req_ready = req_write ? !wb_full : (!rd_full && !rd_pend);
  assign acc_rd    = req_valid && req_ready && !req_write;
  assign push_wr   = req_valid && req_ready &&  req_write;

  nvm_rd_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_tbl (
    .clk          (clk),
    .rst_n        (rst_ni),
    .acc_i        (acc_rd),
    .acc_addr_i   (req_addr),
    .alloc_tag_o  (req_tag),
    .full_o       (rd_full),
    .pend_o       (rd_pend),
    .pend_addr_o  (pend_addr),
    .pend_tag_o   (pend_tag),
    .pend_iss_i   (rd_iss),
    .md_rd_ready_i(md_rd_ready),
    .md_rd_tag_i  (md_rd_tag),
    .md_rd_data_i (md_rd_data),
    .rsp_valid_o  (rsp_valid),
    .rsp_tag_o    (rsp_tag),
    .rsp_addr_o   (rsp_addr),
    .rsp_data_o   (rsp_data)
  );

  nvm_wr_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk        (clk),
    .rst_n      (rst_ni),
    .push_i     (push_wr),
    .push_addr_i(req_addr),
    .push_data_i(req_wdata),
    .full_o     (wb_full),
    .iss_valid_o(wb_v),
    .iss_addr_o (wb_addr),
    .iss_data_o (wb_data),
    .iss_i      (wr_iss),
    .done_i     (md_wr_done)
  );

  nvm_cmd_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_ni),
    .rd_v_i    (rd_pend),
    .rd_addr_i (pend_addr),
    .rd_tag_i  (pend_tag),
    .wr_v_i    (wb_v),
    .wr_addr_i (wb_addr),
    .wr_data_i (wb_data),
    .md_ready_i(md_cmd_ready),
    .md_valid_o(md_cmd_valid),
    .md_write_o(md_cmd_write),
    .md_addr_o (md_cmd_addr),
    .md_tag_o  (md_cmd_tag),
    .md_wdata_o(md_cmd_wdata),
    .rd_iss_o  (rd_iss),
    .wr_iss_o  (wr_iss)
  );

  // R7
  wr_refuse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_write && wb_full) |-> !req_ready);

endmodule

// File: tb/sim_nvm_media_if.sv
module sim_nvm_media_if;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int TW = 3;
  localparam int NT = 1 << TW;
  localparam int WD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready;
  logic [TW-1:0] req_tag;
  logic          rsp_valid;
  logic [TW-1:0] rsp_tag;
  logic [AW-1:0] rsp_addr;
  logic [DW-1:0] rsp_data;
  logic          md_cmd_valid, md_cmd_write;
  logic          md_cmd_ready = 1'b0;
  logic [AW-1:0] md_cmd_addr;
  logic [TW-1:0] md_cmd_tag;
  logic [DW-1:0] md_cmd_wdata;
  logic          md_rd_ready = 1'b0;
  logic [TW-1:0] md_rd_tag = '0;
  logic [DW-1:0] md_rd_data = '0;
  logic          md_wr_done = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference model state
  bit            m_busy [NT];
  logic [AW-1:0] m_addr [NT];
  bit            m_pend;
  logic [AW-1:0] m_paddr;
  logic [TW-1:0] m_ptag;
  logic [AW-1:0] m_wa [WD];
  logic [DW-1:0] m_wd [WD];
  int            m_wcnt, m_niss;
  bit            m_held, m_hwr;
  bit            m_rv;
  logic [TW-1:0] m_rtag;
  logic [AW-1:0] m_raddr;
  logic [DW-1:0] m_rdata;

  always #5 clk = ~clk;

  nvm_media_if #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .WB_DEPTH(WD)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .md_cmd_valid(md_cmd_valid), .md_cmd_ready(md_cmd_ready), .md_cmd_write(md_cmd_write),
    .md_cmd_addr(md_cmd_addr), .md_cmd_tag(md_cmd_tag), .md_cmd_wdata(md_cmd_wdata),
    .md_rd_ready(md_rd_ready), .md_rd_tag(md_rd_tag), .md_rd_data(md_rd_data),
    .md_wr_done(md_wr_done)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int low_free();
    for (int i = 0; i < NT; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  // One cycle: drive at negedge, check, advance model, wait for next negedge
  task automatic step(input bit v, input bit w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input bit cr, input bit rr,
                      input logic [TW-1:0] rt, input logic [DW-1:0] rdat, input bit wd);
    int  lf;
    bit  rdy, selwr, ev, iss, rel;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    md_cmd_ready = cr; md_rd_ready = rr; md_rd_tag = rt; md_rd_data = rdat;
    md_wr_done = wd;
    #1;
    lf  = low_free();
    rdy = w ? (m_wcnt < WD) : ((lf >= 0) && !m_pend);
    chk("R3 R7 R11 req_ready", req_ready, rdy);
    if (lf >= 0) chk("R2 req_tag", req_tag, lf);
    selwr = m_held ? m_hwr : !m_pend;
    ev    = selwr ? (m_wcnt > m_niss) : m_pend;
    chk("R6 R9 R10 md_cmd_valid", md_cmd_valid, ev);
    if (ev) begin
      chk("R9 R10 md_cmd_write", md_cmd_write, selwr);
      if (selwr) begin
        chk("R6 md_cmd_addr", md_cmd_addr, m_wa[m_niss]);
        chk("R6 md_cmd_wdata", md_cmd_wdata, m_wd[m_niss]);
      end else begin
        chk("R2 md_cmd_addr", md_cmd_addr, m_paddr);
        chk("R2 md_cmd_tag", md_cmd_tag, m_ptag);
      end
    end
    chk("R4 R5 rsp_valid", rsp_valid, m_rv);
    if (m_rv) begin
      chk("R4 rsp_tag", rsp_tag, m_rtag);
      chk("R4 rsp_addr", rsp_addr, m_raddr);
      chk("R4 rsp_data", rsp_data, m_rdata);
    end
    // model update
    iss  = ev && cr;
    m_rv = rr && m_busy[rt];
    if (m_rv) begin
      m_rtag = rt; m_raddr = m_addr[rt]; m_rdata = rdat; m_busy[rt] = 1'b0;
    end
    rel = wd && (m_niss > 0);
    if (iss && !selwr) m_pend = 1'b0;
    if (iss && selwr)  m_niss++;
    if (rel) begin
      for (int i = 0; i < WD - 1; i++) begin m_wa[i] = m_wa[i+1]; m_wd[i] = m_wd[i+1]; end
      m_wcnt--; m_niss--;
    end
    if (v && rdy && w) begin
      m_wa[m_wcnt] = a; m_wd[m_wcnt] = d; m_wcnt++;
    end
    if (v && rdy && !w) begin
      m_busy[lf] = 1'b1; m_addr[lf] = a;
      m_pend = 1'b1; m_paddr = a; m_ptag = TW'(lf);
    end
    m_held = ev && !cr;
    m_hwr  = selwr;
    @(negedge clk);
  endtask

  task automatic idle(input bit cr);
    step(0, 0, '0, '0, cr, 0, '0, '0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    for (int i = 0; i < NT; i++) begin m_busy[i] = 0; m_addr[i] = '0; end
    m_pend = 0; m_wcnt = 0; m_niss = 0; m_held = 0; m_hwr = 0; m_rv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    chk("R1 req_ready", req_ready, 1'b1);
    chk("R1 md_cmd_valid", md_cmd_valid, 1'b0);
    chk("R1 rsp_valid", rsp_valid, 1'b0);
    @(negedge clk);

    // R2 R3 R11: fill every tag, reads refused while one waits and when full
    for (int i = 0; i < 2 * NT + 2; i++)
      step(1, 0, AW'(16'h0100 + i), '0, 1, 0, '0, '0, 0);
    step(1, 0, 16'h0F00, '0, 1, 0, '0, '0, 0);
    // R4 out of order completion, R5 stray repeat
    step(0, 0, '0, '0, 1, 1, 3'd5, 32'hAAAA0005, 0);
    step(0, 0, '0, '0, 1, 1, 3'd5, 32'hBBBB0005, 0);
    step(0, 0, '0, '0, 1, 1, 3'd2, 32'hAAAA0002, 0);
    idle(1);

    // R7 R9 R10: stall the bus, fill the buffer, then queue a read
    for (int i = 0; i < WD + 1; i++)
      step(1, 1, AW'(16'h2000 + i), DW'(32'hD000_0000 + i), 0, 0, '0, '0, 0);
    step(1, 0, 16'h3000, '0, 0, 0, '0, '0, 0);
    idle(0);
    idle(1);
    idle(1);
    // R8 releases then stray completions
    for (int i = 0; i < 8; i++) step(0, 0, '0, '0, 1, 0, '0, '0, 1);
    for (int i = 0; i < NT; i++) step(0, 0, '0, '0, 1, 1, TW'(i), DW'(32'hC000_0000 + i), 0);
    idle(1);

    // Random traffic
    for (int n = 0; n < 4000; n++)
      step(($urandom % 2) == 0, ($urandom % 2) == 0, AW'($urandom), DW'($urandom),
           ($urandom % 4) != 0, ($urandom % 3) == 0, TW'($urandom), DW'($urandom),
           ($urandom % 3) == 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule